// File: doc/BRIEF.md
# Bus Request/Grant Handover Arbiter

This block sits on the processor side of a two-signal bus handover. An external master pulls an active-low request line low at any moment: in the middle of a local bus cycle or between cycles. The block brings that request into the local clock domain through a chain of synchronizing flops. It then decides when to drive the active-low grant output low. It watches the local bus engine for three conditions: a cycle to which the processor has already committed, a cycle that is running (the address strobe is active), and an indivisible read-modify-write sequence.

A grant tells the requester that the bus will be free once the current cycle ends, so the grant may overlap a data transfer that is still running. When the cycle ends, the block removes the processor's own bus-drive enable, which the pad logic uses to tri-state. It keeps the grant low for as long as the request stays low. Once the withdrawal of the request has been seen, the block returns the grant and then takes the bus back. Requests are still honoured while the processor is held in reset, is halted, or has stopped after a double bus fault.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While `rst` is sampled high, and on the first edge after it, `grant_n` is 1 and `bus_drive_en` is 1.
- R2: With no hold condition, a request that is held low is granted on exactly the SYNC_STAGES+1-th rising edge after it is first sampled low (the third edge when SYNC_STAGES is 2). The grant never comes earlier.
- R3: While `cyc_pend` is 1 and `cyc_start` is 0, and none of the stall inputs is 1, no new grant is issued. The grant asserts on the edge that samples `cyc_start` at 1.
- R4: While `rmw_lock` is 1, no new grant is issued, whatever the other inputs are. The grant asserts on the first edge that samples `rmw_lock` at 0.
- R5: While any of `cpu_reset`, `cpu_halt` or `dbl_fault` is 1, `cyc_pend` has no effect, and a request is granted with the latency of R2.
- R6: A grant may assert while `as_active` is 1. `bus_drive_en` stays 1 for as long as `as_active` is sampled 1.
- R7: While the grant is asserted, `bus_drive_en` falls on the first edge that samples `as_active` at 0.
- R8: The grant stays low while the synchronized request stays low. It returns high on the first edge at which the synchronizer reports the request withdrawn.
- R9: If the bus had been released, `bus_drive_en` returns to 1 exactly one edge after `grant_n` returns to 1. If the request is withdrawn before the current cycle ends, `bus_drive_en` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| req_n_async | input | 1 | Active-low external bus request, asynchronous |
| cyc_pend | input | 1 | The bus engine has committed to a cycle that has not yet begun |
| cyc_start | input | 1 | Strobe: the committed cycle begins in this clock |
| as_active | input | 1 | A local bus cycle is in progress (address strobe asserted) |
| rmw_lock | input | 1 | A read-modify-write sequence is running |
| cpu_reset | input | 1 | The processor is held in reset |
| cpu_halt | input | 1 | The processor is halted |
| dbl_fault | input | 1 | The processor has stopped after a double bus fault |
| grant_n | output | 1 | Active-low bus grant, registered |
| bus_drive_en | output | 1 | The processor drives the bus pins, registered |

## Verification
Two events can fall in the same clock: the request being withdrawn and the local cycle ending. Withdrawal must win. When both are seen at the same edge, the grant goes away and the bus is never released. The bench provokes this by holding the address strobe active through a grant, then dropping it at each offset from zero to four clocks after the request rises. A behavioural model checks `grant_n` and `bus_drive_en` on every clock, and it judges whether the drive enable dipped and for how long.

// File: rtl/bga_pkg.sv
package bga_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE     = 2'd0,
    ARB_GRANTED  = 2'd1,
    ARB_RELEASED = 2'd2,
    ARB_RECLAIM  = 2'd3
  } arb_state_t;

  localparam int unsigned STALL_SRCS = 3;

endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  output logic req_seen
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= ~req_n_async;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign req_seen = chain_q[LAST];

endmodule

// File: rtl/bga_hold.sv
module bga_hold #(
  parameter int unsigned N_STALL = 3
) (
  input  logic               cyc_pend,
  input  logic               cyc_start,
  input  logic               rmw_lock,
  input  logic [N_STALL-1:0] stall_src,
  output logic               hold
);
  logic stalled;
  logic committed_waiting;

  always_comb begin
    stalled           = |stall_src;
    committed_waiting = cyc_pend & ~cyc_start & ~stalled;
    hold              = rmw_lock | committed_waiting;
  end

endmodule

// File: rtl/bga_ctrl.sv
module bga_ctrl
  import bga_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_seen,
  input  logic hold,
  input  logic as_active,
  output logic grant_q,
  output logic drive_q
);
  arb_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ARB_IDLE;
      grant_q <= 1'b0;
      drive_q <= 1'b1;
    end else begin
      unique case (st_q)
        ARB_IDLE: begin
          if (req_seen && !hold) begin
            grant_q <= 1'b1;
            st_q    <= ARB_GRANTED;
          end
        end
        ARB_GRANTED: begin
          if (!req_seen) begin
            grant_q <= 1'b0;
            st_q    <= ARB_IDLE;
          end else if (!as_active) begin
            drive_q <= 1'b0;
            st_q    <= ARB_RELEASED;
          end
        end
        ARB_RELEASED: begin
          if (!req_seen) begin
            grant_q <= 1'b0;
            st_q    <= ARB_RECLAIM;
          end
        end
        ARB_RECLAIM: begin
          drive_q <= 1'b1;
          st_q    <= ARB_IDLE;
        end
        default: st_q <= ARB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  input  logic cyc_pend,
  input  logic cyc_start,
  input  logic as_active,
  input  logic rmw_lock,
  input  logic cpu_reset,
  input  logic cpu_halt,
  input  logic dbl_fault,
  output logic grant_n,
  output logic bus_drive_en
);
  localparam int unsigned NS = bga_pkg::STALL_SRCS;

  logic          req_seen;
  logic          hold;
  logic          grant_q;
  logic          drive_q;
  logic [NS-1:0] stall_src;

  assign stall_src = {dbl_fault, cpu_halt, cpu_reset};

  bga_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_n_async(req_n_async), .req_seen(req_seen)
  );

  bga_hold #(.N_STALL(NS)) u_hold (
    .cyc_pend(cyc_pend), .cyc_start(cyc_start), .rmw_lock(rmw_lock),
    .stall_src(stall_src), .hold(hold)
  );

  bga_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_seen(req_seen), .hold(hold),
    .as_active(as_active), .grant_q(grant_q), .drive_q(drive_q)
  );

  assign grant_n      = ~grant_q;
  assign bus_drive_en = drive_q;

endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic cyc_pend,
  input logic cyc_start,
  input logic as_active,
  input logic rmw_lock,
  input logic cpu_reset,
  input logic cpu_halt,
  input logic dbl_fault,
  input logic grant_n,
  input logic bus_drive_en
);
  logic any_stall;
  assign any_stall = cpu_reset | cpu_halt | dbl_fault;

  // R3
  grant_defer_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_n) |-> !($past(cyc_pend) && !$past(cyc_start) && !$past(any_stall)));

  // R4
  rmw_block_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_n) |-> !$past(rmw_lock));

  // R7
  release_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_drive_en) |-> (!grant_n && !$past(grant_n) && !$past(as_active)));

  // R9
  reclaim_next_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(grant_n) && !bus_drive_en) |=> bus_drive_en);

  // R9
  off_only_when_granted_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_drive_en |-> (!grant_n || !$past(grant_n)));

endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk chk_i (
  .clk(clk), .rst(rst), .cyc_pend(cyc_pend), .cyc_start(cyc_start),
  .as_active(as_active), .rmw_lock(rmw_lock), .cpu_reset(cpu_reset),
  .cpu_halt(cpu_halt), .dbl_fault(dbl_fault), .grant_n(grant_n),
  .bus_drive_en(bus_drive_en)
);

// File: tb/bus_grant_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_grant_arbiter_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n_async = 1'b1;
  logic cyc_pend = 1'b0, cyc_start = 1'b0, as_active = 1'b0, rmw_lock = 1'b0;
  logic cpu_reset = 1'b0, cpu_halt = 1'b0, dbl_fault = 1'b0;
  logic grant_n, bus_drive_en;

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  bus_grant_arbiter #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .req_n_async(req_n_async), .cyc_pend(cyc_pend),
    .cyc_start(cyc_start), .as_active(as_active), .rmw_lock(rmw_lock),
    .cpu_reset(cpu_reset), .cpu_halt(cpu_halt), .dbl_fault(dbl_fault),
    .grant_n(grant_n), .bus_drive_en(bus_drive_en)
  );

  // Behavioural reference: delay queue for the request, phase integer.
  int rq[$];
  int phase = 0;
  bit m_grant = 0, m_drive = 1;

  always @(posedge clk) begin
    int rec;
    bit blocked;
    cyc++;
    if (rst) begin
      rq = {};
      for (int i = 0; i < SYNC; i++) rq.push_back(0);
      phase = 0; m_grant = 0; m_drive = 1;
    end else begin
      rec = rq.pop_front();
      rq.push_back(req_n_async ? 0 : 1);
      blocked = rmw_lock ||
                (cyc_pend && !cyc_start && !(cpu_reset || cpu_halt || dbl_fault));
      case (phase)
        0: if (rec == 1 && !blocked) begin m_grant = 1; phase = 1; end
        1: if (rec == 0) begin m_grant = 0; phase = 0; end
           else if (!as_active) begin m_drive = 0; phase = 2; end
        2: if (rec == 0) begin m_grant = 0; phase = 3; end
        default: begin m_drive = 1; phase = 0; end
      endcase
    end
  end

  task automatic check(string t, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cyc > 1) begin
      check(tag, "grant_n vs model", grant_n, !m_grant);
      check(tag, "bus_drive_en vs model", bus_drive_en, m_drive);
    end
  end

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_n_async = 1'b1; cyc_pend = 0; cyc_start = 0;
    as_active = 0; rmw_lock = 0; cpu_reset = 0; cpu_halt = 0; dbl_fault = 0;
    clocks(2);
    rst = 1'b0;
  endtask

  task automatic release_req();
    req_n_async = 1'b1;
    clocks(6);
  endtask

  initial begin
    int n;
    // R1 reset state
    do_reset();
    check("R1", "grant_n after reset", grant_n, 1);
    check("R1", "bus_drive_en after reset", bus_drive_en, 1);
    clocks(2);

    // R2 latency
    tag = "R2";
    req_n_async = 1'b0;
    n = 0;
    while (grant_n && n < 20) begin clocks(1); n++; end
    check("R2", "grant latency in clocks", n, SYNC + 1);
    // R8 holds while request held
    tag = "R8";
    clocks(5);
    check("R8", "grant held", grant_n, 0);
    check("R7", "drive released with idle bus", bus_drive_en, 0);
    req_n_async = 1'b1;
    clocks(SYNC + 1);
    check("R8", "grant returned after withdrawal", grant_n, 1);
    tag = "R9";
    check("R9", "drive not yet back", bus_drive_en, 0);
    clocks(1);
    check("R9", "drive back one clock later", bus_drive_en, 1);
    clocks(3);

    // R3 committed cycle defers grant
    tag = "R3";
    cyc_pend = 1; as_active = 1;
    req_n_async = 1'b0;
    clocks(8);
    check("R3", "grant withheld while committed", grant_n, 1);
    cyc_start = 1;
    clocks(1);
    check("R3", "grant on cycle start", grant_n, 0);
    cyc_start = 0; cyc_pend = 0;
    clocks(3);
    check("R6", "drive kept while cycle runs", bus_drive_en, 1);
    tag = "R7";
    as_active = 0;
    clocks(1);
    check("R7", "drive off after cycle end", bus_drive_en, 0);
    release_req();

    // R4 locked sequence
    tag = "R4";
    rmw_lock = 1; cpu_halt = 1;
    req_n_async = 1'b0;
    clocks(8);
    check("R4", "grant withheld under lock", grant_n, 1);
    rmw_lock = 0;
    clocks(1);
    check("R4", "grant once lock drops", grant_n, 0);
    cpu_halt = 0;
    release_req();

    // R5 stall states mask the committed cycle
    for (int s = 0; s < 3; s++) begin
      tag = "R5";
      cpu_reset = (s == 0); cpu_halt = (s == 1); dbl_fault = (s == 2);
      cyc_pend = 1;
      req_n_async = 1'b0;
      clocks(SYNC + 1);
      check("R5", "grant in stall state", grant_n, 0);
      cyc_pend = 0; cpu_reset = 0; cpu_halt = 0; dbl_fault = 0;
      release_req();
    end

    // R9 race: withdrawal against cycle end at several offsets
    for (int off = 0; off < 5; off++) begin
      tag = "R9";
      as_active = 1;
      req_n_async = 1'b0;
      clocks(SYNC + 2);
      check("R6", "granted during cycle", grant_n, 0);
      req_n_async = 1'b1;
      clocks(off);
      as_active = 0;
      clocks(6);
      check("R9", "settled grant", grant_n, 1);
      check("R9", "settled drive", bus_drive_en, 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule